// File: doc/BRIEF.md
# Write-Protected Memory Arbiter with Command Port

This block shares one word-addressed memory between a processor port and an external command port. The command port can reach every word whether the processor is running or held in reset. The processor's writes are screened against a hardware write-protect mask that holds one bit for each sixteenth of the address space. Every write from either port must also pass an external arm discrete. A processor write that the mask blocks is dropped and leaves a sticky flag, which only the command port can clear.

Storage is split into banks, and a discrete input chooses which bank all traffic uses. Only that bank is touched, and no parity is kept. While neither port holds the array, a background scrubber walks the selected bank one word per idle cycle. At the end of each full pass it publishes a 16-bit modular sum with a one-cycle done strobe, then starts the next pass. The command port also owns a set/clear clamp that holds the processor in reset.

Top module: `wp_mem_arbiter`

## Requirements
- R1: When `cmd_req` and `cpu_req` are high in the same cycle, the command access is performed and `cpu_gnt` stays low. The processor access is granted in the first cycle without a command request.
- R2: A granted read on either port returns the addressed word on its `*_rdata` output one cycle later, with its `*_rvalid` high for that cycle.
- R3: A processor write is dropped when the mask bit indexed by the top 4 address bits (`cpu_addr[ADDR_W-1:ADDR_W-4]`) is 1. Such a write sets `wp_viol`. A pulse on `cmd_wp_load` loads the mask from `cmd_wp_mask`, and the new mask applies from the next cycle. Command-port writes ignore the mask.
- R4: While `wr_arm` is low, every array write from either port is dropped. A processor write to an unprotected region then leaves `wp_viol` unchanged.
- R5: `wp_viol` stays set until a `cmd_viol_clr` pulse is given in a cycle with no new violation.
- R6: While `cpu_hold` is high, processor requests get no grant and have no effect. Command reads and writes still complete normally.
- R7: `cmd_hold_set` sets `cpu_hold` and `cmd_hold_clr` clears it, each from the next cycle.
- R8: All accesses and the scrubber use the bank that `bank_sel` names. A write to one bank leaves the same address in the other bank unchanged. Changing `bank_sel` restarts the scrub pass.
- R9: At the end of each pass, `sum_value` holds the sum modulo 2^16 of every word in the selected bank, and `sum_done` is high for exactly one cycle.
- R10: In any cycle in which a port holds the array, the scrubber neither advances nor finishes. It resumes at the same word, so a pass interrupted by reads still yields the correct sum.
- R11: After reset, `cpu_hold`, `wp_viol`, `sum_done`, both `*_rvalid` outputs and `sum_value` are 0, and the write-protect mask is all ones, so every region is protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_arm | input | 1 | Hardware discrete that allows array writes |
| bank_sel | input | BANK_W | Selects the active bank |
| cmd_req | input | 1 | Command port access request |
| cmd_we | input | 1 | Command access is a write |
| cmd_addr | input | ADDR_W | Command word address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_rdata | output | DATA_W | Command read data |
| cmd_rvalid | output | 1 | Command read data valid |
| cmd_wp_load | input | 1 | Load the write-protect mask |
| cmd_wp_mask | input | 16 | New write-protect mask, one bit per region |
| cmd_viol_clr | input | 1 | Clear the violation flag |
| cmd_hold_set | input | 1 | Engage the processor reset clamp |
| cmd_hold_clr | input | 1 | Release the processor reset clamp |
| cpu_hold | output | 1 | Processor reset clamp |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_gnt | output | 1 | Processor access granted this cycle |
| cpu_rdata | output | DATA_W | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| wp_viol | output | 1 | Sticky write-protect violation flag |
| sum_value | output | SUM_W | Last completed checksum |
| sum_done | output | 1 | One-cycle strobe at the end of each pass |

## Verification
The protection logic is driven from a vector table of processor writes. The table pairs protected and open regions, including the first and last word of a region, and drives the arm discrete both high and low. This separates the mask check from the arm barrier, and also separates which of the two sets the flag. Each vector first presets the target word through the command port, so a write that was dropped reads back the preset pattern rather than stale data. Checksum passes are run with the bank idle, with a long burst of processor reads in the middle of a pass, and after a bank switch. This shows whether pausing and restarting leave the sum unchanged. The collision, clamp and bank cases are directed tests; each checks the result through a read-back on a port.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
   localparam int REG_BITS = 4;
   localparam int REG_CNT  = 1 << REG_BITS;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_CMD  = 2'd1,
      SRC_CPU  = 2'd2
   } src_e;
endpackage

// File: rtl/wpa_arb.sv
module wpa_arb
   import wpa_pkg::*;
(
   input  logic cmd_req,
   input  logic cpu_req,
   input  logic cpu_hold,
   output src_e src,
   output logic cpu_gnt
);
   always_comb begin
      if (cmd_req)                  src = SRC_CMD;
      else if (cpu_req && !cpu_hold) src = SRC_CPU;
      else                          src = SRC_NONE;
   end

   assign cpu_gnt = (src == SRC_CPU);
endmodule

// File: rtl/wpa_guard.sv
module wpa_guard
   import wpa_pkg::*;
#(
   parameter int ADDR_W          = 6,
   parameter bit WP_RESET_LOCKED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  src_e                src,
   input  logic                cmd_we,
   input  logic                cpu_we,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic                wr_arm,
   input  logic                wp_load,
   input  logic [REG_CNT-1:0]  wp_mask_in,
   input  logic                viol_clr,
   output logic                wr_fire,
   output logic                wp_viol
);
   localparam logic [REG_CNT-1:0] MASK_RST = WP_RESET_LOCKED ? {REG_CNT{1'b1}} : {REG_CNT{1'b0}};

   logic [REG_CNT-1:0]  mask_q;
   logic [REG_BITS-1:0] region;
   logic [REG_CNT-1:0]  hit_vec;
   logic                cpu_hit;
   logic                cpu_wr;

   assign region = cpu_addr[ADDR_W-1 -: REG_BITS];

   for (genvar g = 0; g < REG_CNT; g++) begin : g_region
      assign hit_vec[g] = (region == REG_BITS'(g)) && mask_q[g];
   end

   assign cpu_hit = |hit_vec;
   assign cpu_wr  = (src == SRC_CPU) && cpu_we;

   always_comb begin
      wr_fire = 1'b0;
      if (wr_arm) begin
         if (src == SRC_CMD) wr_fire = cmd_we;
         else if (cpu_wr)    wr_fire = !cpu_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= MASK_RST;
         wp_viol <= 1'b0;
      end else begin
         if (wp_load) mask_q <= wp_mask_in;
         if (cpu_wr && cpu_hit) wp_viol <= 1'b1;
         else if (viol_clr)     wp_viol <= 1'b0;
      end
   end
endmodule

// File: rtl/wpa_store.sv
module wpa_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int NBANKS = 2,
   localparam int BANK_W = $clog2(NBANKS),
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [BANK_W-1:0] bank,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] scan_addr,
   output logic [DATA_W-1:0] scan_data
);
   logic [DATA_W-1:0] rd_vec [NBANKS];
   logic [DATA_W-1:0] sc_vec [NBANKS];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (bank == BANK_W'(b))) mem[addr] <= wdata;
      end
      assign rd_vec[b] = mem[addr];
      assign sc_vec[b] = mem[scan_addr];
   end

   assign rdata     = rd_vec[bank];
   assign scan_data = sc_vec[bank];
endmodule

// File: rtl/wpa_scrub.sv
module wpa_scrub #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int SUM_W  = 16,
   parameter int BANK_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic [BANK_W-1:0] bank,
   input  logic [DATA_W-1:0] scan_word,
   output logic [ADDR_W-1:0] scan_addr,
   output logic [SUM_W-1:0]  sum_value,
   output logic              sum_done
);
   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   logic [SUM_W-1:0]  acc;
   logic [SUM_W-1:0]  acc_next;
   logic [BANK_W-1:0] bank_q;

   assign acc_next = acc + SUM_W'(scan_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_addr <= '0;
         acc       <= '0;
         sum_value <= '0;
         sum_done  <= 1'b0;
         bank_q    <= '0;
      end else begin
         sum_done <= 1'b0;
         bank_q   <= bank;
         if (bank != bank_q) begin
            scan_addr <= '0;
            acc       <= '0;
         end else if (idle) begin
            if (scan_addr == LAST) begin
               sum_value <= acc_next;
               sum_done  <= 1'b1;
               acc       <= '0;
               scan_addr <= '0;
            end else begin
               acc       <= acc_next;
               scan_addr <= scan_addr + ADDR_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wp_mem_arbiter.sv
module wp_mem_arbiter
   import wpa_pkg::*;
#(
   parameter int ADDR_W          = 6,
   parameter int DATA_W          = 16,
   parameter int SUM_W           = 16,
   parameter int NBANKS          = 2,
   parameter bit WP_RESET_LOCKED = 1'b1,
   localparam int BANK_W         = $clog2(NBANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_arm,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              cmd_req,
   input  logic              cmd_we,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic              cmd_rvalid,
   input  logic              cmd_wp_load,
   input  logic [15:0]       cmd_wp_mask,
   input  logic              cmd_viol_clr,
   input  logic              cmd_hold_set,
   input  logic              cmd_hold_clr,
   output logic              cpu_hold,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_gnt,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rvalid,
   output logic              wp_viol,
   output logic [SUM_W-1:0]  sum_value,
   output logic              sum_done
);
   if (ADDR_W < REG_BITS) begin : g_bad_addr
      $error("ADDR_W must cover the region index bits");
   end
   if (NBANKS < 2 || (NBANKS & (NBANKS - 1)) != 0) begin : g_bad_banks
      $error("NBANKS must be a power of two, at least 2");
   end
   if (SUM_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("SUM_W and DATA_W must be positive");
   end

   src_e              src;
   logic              wr_fire;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_wdata;
   logic [DATA_W-1:0] rd_word;
   logic [ADDR_W-1:0] scan_addr;
   logic [DATA_W-1:0] scan_word;

   wpa_arb u_arb (
      .cmd_req  (cmd_req),
      .cpu_req  (cpu_req),
      .cpu_hold (cpu_hold),
      .src      (src),
      .cpu_gnt  (cpu_gnt)
   );

   assign acc_addr  = (src == SRC_CMD) ? cmd_addr  : cpu_addr;
   assign acc_wdata = (src == SRC_CMD) ? cmd_wdata : cpu_wdata;

   wpa_guard #(.ADDR_W(ADDR_W), .WP_RESET_LOCKED(WP_RESET_LOCKED)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src),
      .cmd_we     (cmd_we),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .wr_arm     (wr_arm),
      .wp_load    (cmd_wp_load),
      .wp_mask_in (cmd_wp_mask),
      .viol_clr   (cmd_viol_clr),
      .wr_fire    (wr_fire),
      .wp_viol    (wp_viol)
   );

   wpa_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANKS(NBANKS)) u_store (
      .clk       (clk),
      .bank      (bank_sel),
      .we        (wr_fire),
      .addr      (acc_addr),
      .wdata     (acc_wdata),
      .rdata     (rd_word),
      .scan_addr (scan_addr),
      .scan_data (scan_word)
   );

   wpa_scrub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W), .BANK_W(BANK_W)) u_scrub (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (src == SRC_NONE),
      .bank      (bank_sel),
      .scan_word (scan_word),
      .scan_addr (scan_addr),
      .sum_value (sum_value),
      .sum_done  (sum_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_rvalid <= 1'b0;
         cpu_rvalid <= 1'b0;
         cmd_rdata  <= '0;
         cpu_rdata  <= '0;
         cpu_hold   <= 1'b0;
      end else begin
         cmd_rvalid <= (src == SRC_CMD) && !cmd_we;
         cpu_rvalid <= (src == SRC_CPU) && !cpu_we;
         if ((src == SRC_CMD) && !cmd_we) cmd_rdata <= rd_word;
         if ((src == SRC_CPU) && !cpu_we) cpu_rdata <= rd_word;
         if (cmd_hold_set)      cpu_hold <= 1'b1;
         else if (cmd_hold_clr) cpu_hold <= 1'b0;
      end
   end
endmodule

// File: rtl/wpa_checker.sv
module wpa_checker (
   input logic clk,
   input logic rst_n,
   input logic cmd_req,
   input logic cpu_req,
   input logic cpu_we,
   input logic cpu_gnt,
   input logic cpu_rvalid,
   input logic cpu_hold,
   input logic cmd_hold_set,
   input logic cmd_hold_clr,
   input logic wp_viol,
   input logic cmd_viol_clr,
   input logic sum_done
);
   assert_cmd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> !cpu_gnt);

   assert_cpu_read_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && !cpu_we) |=> cpu_rvalid);

   assert_viol_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_viol && !cmd_viol_clr) |=> wp_viol);

   assert_hold_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold |-> !cpu_gnt);

   assert_hold_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hold_set |=> cpu_hold);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sum_done |=> !sum_done);

   assert_scrub_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req || cpu_gnt) |=> !sum_done);

   assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |-> cpu_req);

   wire unused_ok = cmd_hold_clr;
endmodule

bind wp_mem_arbiter wpa_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_req      (cmd_req),
   .cpu_req      (cpu_req),
   .cpu_we       (cpu_we),
   .cpu_gnt      (cpu_gnt),
   .cpu_rvalid   (cpu_rvalid),
   .cpu_hold     (cpu_hold),
   .cmd_hold_set (cmd_hold_set),
   .cmd_hold_clr (cmd_hold_clr),
   .wp_viol      (wp_viol),
   .cmd_viol_clr (cmd_viol_clr),
   .sum_done     (sum_done)
);

// File: tb/tb_wp_mem_arbiter.sv
module tb_wp_mem_arbiter;
   localparam int AW = 6;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_arm = 1'b1;
   logic [0:0] bank_sel = 1'b0;
   logic cmd_req = 0, cmd_we = 0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [DW-1:0] cmd_rdata;
   logic cmd_rvalid;
   logic cmd_wp_load = 0;
   logic [15:0] cmd_wp_mask = '0;
   logic cmd_viol_clr = 0, cmd_hold_set = 0, cmd_hold_clr = 0;
   logic cpu_hold;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_gnt;
   logic [DW-1:0] cpu_rdata;
   logic cpu_rvalid;
   logic wp_viol;
   logic [15:0] sum_value;
   logic sum_done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   wp_mem_arbiter dut (
      .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .bank_sel(bank_sel),
      .cmd_req(cmd_req), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .cmd_rvalid(cmd_rvalid),
      .cmd_wp_load(cmd_wp_load), .cmd_wp_mask(cmd_wp_mask), .cmd_viol_clr(cmd_viol_clr),
      .cmd_hold_set(cmd_hold_set), .cmd_hold_clr(cmd_hold_clr), .cpu_hold(cpu_hold),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .wp_viol(wp_viol), .sum_value(sum_value), .sum_done(sum_done)
   );

   typedef struct packed {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          arm;
      logic          ok;
      logic          viol;
   } vec_t;

   // mask 16'h00F0 protects regions 4..7 (addresses 16..31)
   localparam vec_t VECS [8] = '{
      '{6'd0,  16'hA001, 1'b1, 1'b1, 1'b0},
      '{6'd16, 16'hA002, 1'b1, 1'b0, 1'b1},
      '{6'd31, 16'hA003, 1'b1, 1'b0, 1'b1},
      '{6'd32, 16'hA004, 1'b1, 1'b1, 1'b0},
      '{6'd15, 16'hA005, 1'b1, 1'b1, 1'b0},
      '{6'd40, 16'hA006, 1'b0, 1'b0, 1'b0},
      '{6'd63, 16'hA007, 1'b1, 1'b1, 1'b0},
      '{6'd20, 16'hA008, 1'b0, 1'b0, 1'b1}
   };

   function automatic logic [DW-1:0] fill(input int a);
      return DW'(a * 613 + 17);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cmd_req = 1; cmd_we = 1; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_req = 0; cmd_we = 0;
   endtask

   task automatic cmd_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
      @(negedge clk);
      cmd_req = 1; cmd_we = 0; cmd_addr = a;
      @(negedge clk);
      cmd_req = 0;
      d = cmd_rdata; v = cmd_rvalid;
   endtask

   task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); cmd_viol_clr = 1;
      @(negedge clk); cmd_viol_clr = 0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (sum_done) begin seen = 1; break; end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      logic          rv;
      logic [DW-1:0] exp_sum;
      bit            seen;
      bit            early;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 hold", cpu_hold, 0);
      chk("R11 viol", wp_viol, 0);
      chk("R11 done", sum_done, 0);
      chk("R11 rvalid", {cmd_rvalid, cpu_rvalid}, 0);
      chk("R11 sum", sum_value, 0);

      // R11/R3: reset mask protects everything
      cmd_write(6'd0, 16'h1111);
      cpu_write(6'd0, 16'h2222);
      chk("R11 viol after locked write", wp_viol, 1);
      cmd_read(6'd0, rd, rv);
      chk("R11 locked word", rd, 16'h1111);
      chk("R2 cmd rvalid", rv, 1);
      pulse_clr();
      chk("R5 cleared", wp_viol, 0);

      // load mask: regions 4..7 protected
      @(negedge clk); cmd_wp_load = 1; cmd_wp_mask = 16'h00F0;
      @(negedge clk); cmd_wp_load = 0;

      // table walk: R3 mask, R4 barrier
      foreach (VECS[i]) begin
         wr_arm = 1;
         cmd_write(VECS[i].a, 16'h5555);
         wr_arm = VECS[i].arm;
         cpu_write(VECS[i].a, VECS[i].d);
         wr_arm = 1;
         chk(VECS[i].arm ? "R3 viol" : "R4 viol", wp_viol, VECS[i].viol);
         cmd_read(VECS[i].a, rd, rv);
         chk(VECS[i].arm ? "R3 data" : "R4 data", rd, VECS[i].ok ? VECS[i].d : 16'h5555);
         pulse_clr();
      end

      // R4: command write dropped while disarmed
      cmd_write(6'd3, 16'h0F0F);
      wr_arm = 0;
      cmd_write(6'd3, 16'hF0F0);
      wr_arm = 1;
      cmd_read(6'd3, rd, rv);
      chk("R4 cmd barrier", rd, 16'h0F0F);

      // R2: processor read latency
      @(negedge clk); cpu_req = 1; cpu_we = 0; cpu_addr = 6'd3;
      @(negedge clk); cpu_req = 0;
      chk("R2 cpu rvalid", cpu_rvalid, 1);
      chk("R2 cpu rdata", cpu_rdata, 16'h0F0F);

      // R1: collision, command first, processor one cycle later
      @(negedge clk);
      cmd_req = 1; cmd_we = 1; cmd_addr = 6'd1; cmd_wdata = 16'hBEEF;
      cpu_req = 1; cpu_we = 1; cpu_addr = 6'd1; cpu_wdata = 16'hDEAD;
      #1 chk("R1 cpu waits", cpu_gnt, 0);
      @(negedge clk);
      cmd_req = 0; cmd_we = 0;
      #1 chk("R1 cpu granted next", cpu_gnt, 1);
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
      cmd_read(6'd1, rd, rv);
      chk("R1 final word", rd, 16'hDEAD);

      // R5: sticky across idle cycles
      cpu_write(6'd17, 16'h9999);
      repeat (5) @(negedge clk);
      chk("R5 sticky", wp_viol, 1);
      pulse_clr();
      chk("R5 clear", wp_viol, 0);

      // R6/R7: processor clamp
      @(negedge clk); cmd_hold_set = 1;
      @(negedge clk); cmd_hold_set = 0;
      chk("R7 hold set", cpu_hold, 1);
      cmd_write(6'd2, 16'h3333);
      @(negedge clk); cpu_req = 1; cpu_we = 1; cpu_addr = 6'd2; cpu_wdata = 16'h7777;
      #1 chk("R6 no grant", cpu_gnt, 0);
      @(negedge clk); cpu_req = 0; cpu_we = 0;
      cmd_read(6'd2, rd, rv);
      chk("R6 cmd works held", rd, 16'h3333);
      @(negedge clk); cmd_hold_clr = 1;
      @(negedge clk); cmd_hold_clr = 0;
      chk("R7 hold clr", cpu_hold, 0);

      // R9: checksum over a filled bank
      exp_sum = '0;
      for (int a = 0; a < 64; a++) begin
         cmd_write(AW'(a), fill(a));
         exp_sum = exp_sum + fill(a);
      end
      wait_done(seen);
      wait_done(seen);
      chk("R9 done seen", seen, 1);
      chk("R9 sum", sum_value, exp_sum);
      @(negedge clk);
      chk("R9 single pulse", sum_done, 0);

      // R10: pause mid-pass with a burst of reads
      repeat (10) @(negedge clk);
      early = 0;
      cpu_req = 1; cpu_we = 0; cpu_addr = 6'd9;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         if (sum_done) early = 1;
      end
      cpu_req = 0;
      chk("R10 no finish while busy", early, 0);
      wait_done(seen);
      chk("R10 resumed sum", sum_value, exp_sum);

      // R8: bank isolation
      bank_sel = 1'b1;
      cmd_write(6'd5, 16'h1234);
      cmd_read(6'd5, rd, rv);
      chk("R8 bank1 word", rd, 16'h1234);
      bank_sel = 1'b0;
      cmd_read(6'd5, rd, rv);
      chk("R8 bank0 untouched", rd, fill(5));
      wait_done(seen);
      wait_done(seen);
      chk("R8 sum after switch", sum_value, exp_sum);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule